// File: doc/BRIEF.md
# Tile Byte Dot-Product Matrix-Multiply Sequencer

The block holds three tile register files: a destination tile C of 32-bit words, a first source tile A whose words each pack four bytes, and a second source tile B of the same packing. On a start pulse it computes C += A x B. Each step takes one word of A and one word of B, multiplies their four byte pairs, and adds the four products to one accumulator word. Two mode bits choose, independently for A and for B, whether bytes are read as signed or unsigned. The configured shape is captured at start: the destination row count, the destination bytes-per-row and the first source's bytes-per-row. A word count per row is always the byte count divided by four, rounded down.

Each destination row is copied into a temporary row, updated with one step per clock, then written back with every byte at or past the configured width cleared. After the last computed row, all destination rows from the configured count up to the physical maximum are cleared. A single-cycle done pulse ends the operation. A write port and a combinational read port load and inspect the tiles between operations. The configuration is assumed legal: B has at least as many rows as A has words per row, and B rows are at least as wide as C rows.

Top module: `tile_mma_seq`

## Requirements
- R1: After reset every word of all three tiles reads zero and done is low.
- R2: When idle, a write with wr_tile 0, 1 or 2 stores wr_data into tile A, B or C at (wr_row, wr_word); rd_data shows the selected word combinationally; tile code 3 reads zero and its writes change no tile.
- R3: For destination row m below the row count and word n below cfg_c_bytes/4, the result is the old C[m][n] plus, for every k below cfg_a_bytes/4, the four byte products of A[m][k] and B[k][n], all modulo 2^32.
- R4: mode bit 1 set makes every A byte signed (clear: unsigned); mode bit 0 does the same for every B byte, for the whole operation.
- R5: In each computed row, every byte whose byte offset is at or beyond cfg_c_bytes reads zero after the operation, including the upper bytes of a partly covered word; lower bytes of a partly covered word keep their old value.
- R6: Every destination row from the configured row count up to the maximum row count reads zero after the operation; a row count of zero clears the whole tile.
- R7: The configuration and mode are captured at start; start and configuration changes while busy have no effect.
- R8: Writes issued while an operation runs are ignored.
- R9: done is high for exactly one cycle, L cycles after the start edge, where L = rows*(2 + K*N) + (MAXR - rows) + 1 with K = cfg_a_bytes/4 and N = cfg_c_bytes/4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| mode | input | 2 | Bit 1: A bytes signed; bit 0: B bytes signed |
| cfg_rows | input | 5 | Destination (and A) row count, 0..16 |
| cfg_c_bytes | input | 7 | Destination bytes per row, 0..64 |
| cfg_a_bytes | input | 7 | First source bytes per row, 0..64 |
| wr_en | input | 1 | Tile write enable |
| wr_tile | input | 2 | Write target: 0 A, 1 B, 2 C, 3 none |
| wr_row | input | 4 | Write row index |
| wr_word | input | 4 | Write word index within the row |
| wr_data | input | 32 | Write data |
| rd_tile | input | 2 | Read source: 0 A, 1 B, 2 C, 3 zero |
| rd_row | input | 4 | Read row index |
| rd_word | input | 4 | Read word index within the row |
| rd_data | output | 32 | Selected tile word |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions watch, on every cycle, that done never lasts two cycles, that an idle start always leaves the idle state, that the captured shape and mode stay fixed through an operation, that the step counters stay inside the configured word counts, and that the clearing phase only touches rows at or past the row count. The arithmetic itself, the sign handling of each mode, the byte-level clearing of partial words, the exact completion latency and the rejection of writes and restarts while busy can only be shown by the bench comparing the whole destination tile against its own reference loop.

// File: rtl/tile_mma_seq.sv
module tile_mma_seq #(
  parameter int MAXR = 16,
  parameter int MAXB = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [1:0]                  mode,
  input  logic [$clog2(MAXR+1)-1:0]   cfg_rows,
  input  logic [$clog2(MAXB+1)-1:0]   cfg_c_bytes,
  input  logic [$clog2(MAXB+1)-1:0]   cfg_a_bytes,
  input  logic                        wr_en,
  input  logic [1:0]                  wr_tile,
  input  logic [$clog2(MAXR)-1:0]     wr_row,
  input  logic [$clog2(MAXB/4)-1:0]   wr_word,
  input  logic [31:0]                 wr_data,
  input  logic [1:0]                  rd_tile,
  input  logic [$clog2(MAXR)-1:0]     rd_row,
  input  logic [$clog2(MAXB/4)-1:0]   rd_word,
  output logic [31:0]                 rd_data,
  output logic                        done
);
  localparam int MAXW = MAXB / 4;
  localparam int RI   = $clog2(MAXR);
  localparam int WI   = $clog2(MAXW);
  localparam int RN   = $clog2(MAXR + 1);
  localparam int BN   = $clog2(MAXB + 1);

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_CALC, S_WB, S_ZERO} st_t;

  st_t         st;
  logic [31:0] ta  [MAXR][MAXW];
  logic [31:0] tb  [MAXR][MAXW];
  logic [31:0] tc  [MAXR][MAXW];
  logic [31:0] tmp [MAXW];
  logic [RN-1:0] rows_q, m, zr;
  logic [BN-1:0] cb_q, ab_q;
  logic [1:0]    mode_q;
  logic [WI-1:0] k, n;
  logic [WI:0]   kw, nw;
  logic [RI-1:0] m_i, zr_i;

  assign kw   = (WI+1)'(ab_q >> 2);
  assign nw   = (WI+1)'(cb_q >> 2);
  assign m_i  = m[RI-1:0];
  assign zr_i = zr[RI-1:0];

  function automatic logic [31:0] dot4(input logic [31:0] x, input logic [31:0] y,
                                       input logic sx, input logic sy);
    logic [31:0]       acc;
    logic signed [17:0] p;
    acc = '0;
    for (int b = 0; b < 4; b++) begin
      p   = $signed({sx & x[8*b+7], x[8*b +: 8]}) * $signed({sy & y[8*b+7], y[8*b +: 8]});
      acc = acc + 32'(p);
    end
    return acc;
  endfunction

  always_comb begin
    case (rd_tile)
      2'd0:    rd_data = ta[rd_row][rd_word];
      2'd1:    rd_data = tb[rd_row][rd_word];
      2'd2:    rd_data = tc[rd_row][rd_word];
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      rows_q <= '0;
      cb_q   <= '0;
      ab_q   <= '0;
      mode_q <= '0;
      m      <= '0;
      zr     <= '0;
      k      <= '0;
      n      <= '0;
      for (int r = 0; r < MAXR; r++)
        for (int w = 0; w < MAXW; w++) begin
          ta[r][w] <= '0;
          tb[r][w] <= '0;
          tc[r][w] <= '0;
        end
      for (int w = 0; w < MAXW; w++) tmp[w] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (wr_en) begin
            case (wr_tile)
              2'd0:    ta[wr_row][wr_word] <= wr_data;
              2'd1:    tb[wr_row][wr_word] <= wr_data;
              2'd2:    tc[wr_row][wr_word] <= wr_data;
              default: ;
            endcase
          end
          if (start) begin
            rows_q <= cfg_rows;
            cb_q   <= cfg_c_bytes;
            ab_q   <= cfg_a_bytes;
            mode_q <= mode;
            m      <= '0;
            zr     <= cfg_rows;
            st     <= (cfg_rows == '0) ? S_ZERO : S_LOAD;
          end
        end
        S_LOAD: begin
          for (int w = 0; w < MAXW; w++) tmp[w] <= tc[m_i][w];
          k  <= '0;
          n  <= '0;
          st <= (kw == '0 || nw == '0) ? S_WB : S_CALC;
        end
        S_CALC: begin
          tmp[n] <= tmp[n] + dot4(ta[m_i][k], tb[RI'(k)][n], mode_q[1], mode_q[0]);
          if (({1'b0, n} + 1'b1) == nw) begin
            n <= '0;
            if (({1'b0, k} + 1'b1) == kw) st <= S_WB;
            else k <= k + 1'b1;
          end else begin
            n <= n + 1'b1;
          end
        end
        S_WB: begin
          for (int w = 0; w < MAXW; w++)
            for (int b = 0; b < 4; b++)
              tc[m_i][w][8*b +: 8] <= ((w*4 + b) < int'(cb_q)) ? tmp[w][8*b +: 8] : 8'h00;
          m  <= m + 1'b1;
          st <= ((m + 1'b1) == rows_q) ? S_ZERO : S_LOAD;
        end
        S_ZERO: begin
          if (int'(zr) < MAXR) begin
            for (int w = 0; w < MAXW; w++) tc[zr_i][w] <= '0;
            zr <= zr + 1'b1;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_start_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (st != S_IDLE));

  assert_cfg_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && $past(st) != S_IDLE) |->
      ($stable(rows_q) && $stable(cb_q) && $stable(ab_q) && $stable(mode_q)));

  assert_step_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CALC) |-> (({1'b0, k} < kw) && ({1'b0, n} < nw)));

  assert_zero_region_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ZERO) |-> (zr >= rows_q));
endmodule

// File: tb/tb_tile_mma_seq.sv
module tb_tile_mma_seq;
  localparam int CLK_P = 10;
  localparam int MR = 16;
  localparam int MW = 16;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0;
  logic [1:0] mode = '0, wr_tile = '0, rd_tile = '0;
  logic [4:0] cfg_rows = '0;
  logic [6:0] cfg_c_bytes = '0, cfg_a_bytes = '0;
  logic [3:0] wr_row = '0, wr_word = '0, rd_row = '0, rd_word = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic done;

  int checks = 0, errors = 0;
  int unsigned ra [MR][MW];
  int unsigned rb [MR][MW];
  int unsigned rc [MR][MW];

  always #(CLK_P/2) clk = ~clk;

  tile_mma_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .cfg_rows(cfg_rows), .cfg_c_bytes(cfg_c_bytes), .cfg_a_bytes(cfg_a_bytes),
    .wr_en(wr_en), .wr_tile(wr_tile), .wr_row(wr_row), .wr_word(wr_word), .wr_data(wr_data),
    .rd_tile(rd_tile), .rd_row(rd_row), .rd_word(rd_word), .rd_data(rd_data), .done(done)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int unsigned refdot(int unsigned x, int unsigned y, bit sx, bit sy);
    int acc = 0;
    for (int b = 0; b < 4; b++) begin
      int xa = int'((x >> (8*b)) & 255);
      int ya = int'((y >> (8*b)) & 255);
      if (sx && xa > 127) xa -= 256;
      if (sy && ya > 127) ya -= 256;
      acc += xa * ya;
    end
    return int'(acc);
  endfunction

  task automatic wr(input int t, input int r, input int w, input int unsigned d);
    @(negedge clk);
    wr_en = 1'b1; wr_tile = 2'(t); wr_row = 4'(r); wr_word = 4'(w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int unsigned rd(input int t, input int r, input int w);
    rd_tile = 2'(t); rd_row = 4'(r); rd_word = 4'(w);
    return 0;
  endfunction

  task automatic rdw(input int t, input int r, input int w, output int unsigned d);
    void'(rd(t, r, w));
    #1 d = rd_data;
  endtask

  task automatic fill(input int kind);
    for (int r = 0; r < MR; r++)
      for (int w = 0; w < MW; w++) begin
        ra[r][w] = (kind == 1) ? 32'h8080_8080 : (kind == 2) ? 32'hFFFF_FFFF : $urandom;
        rb[r][w] = (kind == 1) ? 32'h8080_8080 : (kind == 2) ? 32'h7F7F_7F7F : $urandom;
        rc[r][w] = $urandom;
        wr(0, r, w, ra[r][w]);
        wr(1, r, w, rb[r][w]);
        wr(2, r, w, rc[r][w]);
      end
  endtask

  task automatic run_op(input int rows, input int cb, input int ab, input int md, input bit disturb);
    int unsigned ex [MR][MW];
    int unsigned tmp [MW];
    int unsigned d;
    int kk = ab / 4, nn = cb / 4, lat = 0, explat;
    string tg = $sformatf("rows=%0d cb=%0d ab=%0d mode=%0d", rows, cb, ab, md);
    for (int r = 0; r < MR; r++)
      for (int w = 0; w < MW; w++) ex[r][w] = rc[r][w];
    for (int r = 0; r < rows; r++) begin
      for (int w = 0; w < MW; w++) tmp[w] = rc[r][w];
      for (int k2 = 0; k2 < kk; k2++)
        for (int n2 = 0; n2 < nn; n2++)
          tmp[n2] += refdot(ra[r][k2], rb[k2][n2], md[1], md[0]);
      for (int w = 0; w < MW; w++) begin
        int unsigned v = 0;
        for (int b = 0; b < 4; b++)
          if (w*4 + b < cb) v |= tmp[w] & (32'hFF << (8*b));
        ex[r][w] = v;
      end
    end
    for (int r = rows; r < MR; r++)
      for (int w = 0; w < MW; w++) ex[r][w] = 0;
    explat = rows * (2 + kk*nn) + (MR - rows) + 1;

    @(negedge clk);
    cfg_rows = 5'(rows); cfg_c_bytes = 7'(cb); cfg_a_bytes = 7'(ab); mode = 2'(md); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && lat < 20000) begin
      if (disturb && lat == 3) begin
        start = 1'b1; cfg_rows = 5'd1; cfg_c_bytes = 7'd4; cfg_a_bytes = 7'd4; mode = ~mode;
        wr_en = 1'b1; wr_tile = 2'd0; wr_row = 4'd0; wr_word = 4'd0; wr_data = ~ra[0][0];
      end else begin
        start = 1'b0; wr_en = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0; wr_en = 1'b0;
    check("R9", {"latency ", tg}, lat, explat);
    @(negedge clk);
    check("R9", {"done single cycle ", tg}, done, 0);
    for (int r = 0; r < MR; r++)
      for (int w = 0; w < MW; w++) begin
        rdw(2, r, w, d);
        if (r >= rows)
          check("R6", $sformatf("cleared row %0d word %0d %s", r, w, tg), d, ex[r][w]);
        else if (w*4 + 3 >= cb)
          check("R5", $sformatf("row %0d word %0d tail %s", r, w, tg), d, ex[r][w]);
        else
          check("R3", $sformatf("R4 row %0d word %0d %s", r, w, tg), d, ex[r][w]);
      end
    if (disturb) begin
      rdw(0, 0, 0, d);
      check("R8", "A write while busy ignored", d, ra[0][0]);
      repeat (30) begin
        @(negedge clk);
        if (done) check("R7", "no second done from busy start", done, 0);
      end
    end
    for (int r = 0; r < MR; r++)
      for (int w = 0; w < MW; w++) rc[r][w] = ex[r][w];
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "done after reset", done, 0);
    for (int t = 0; t < 3; t++) begin
      rdw(t, 5, 7, d);
      check("R1", $sformatf("tile %0d zero after reset", t), d, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 3; t++) begin
      wr(t, 3, 9, 32'hA5A5_0000 + t);
      rdw(t, 3, 9, d);
      check("R2", $sformatf("write/read tile %0d", t), d, 32'hA5A5_0000 + t);
    end
    wr(3, 3, 9, 32'h1234_5678);
    rdw(3, 3, 9, d);
    check("R2", "tile code 3 reads zero", d, 0);
    for (int t = 0; t < 3; t++) begin
      rdw(t, 3, 9, d);
      check("R2", $sformatf("tile code 3 write leaves tile %0d", t), d, 32'hA5A5_0000 + t);
    end

    fill(0);
    for (int md = 0; md < 4; md++) run_op(16, 64, 64, md, 1'b0);
    run_op(5, 10, 12, 3, 1'b0);
    run_op(7, 22, 7, 1, 1'b0);
    run_op(0, 64, 64, 2, 1'b0);
    fill(0);
    run_op(9, 40, 0, 3, 1'b0);
    run_op(16, 64, 4, 0, 1'b0);
    run_op(12, 33, 20, 2, 1'b1);
    fill(1);
    run_op(16, 64, 64, 3, 1'b0);
    run_op(16, 64, 64, 0, 1'b0);
    fill(2);
    run_op(16, 64, 64, 2, 1'b0);
    run_op(16, 64, 64, 1, 1'b0);
    fill(0);
    for (int i = 0; i < 6; i++)
      run_op(int'($urandom_range(16, 1)), int'($urandom_range(64, 0)),
             int'($urandom_range(64, 0)), int'($urandom_range(3, 0)), 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule